// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block chooses which of a set of interrupt request lines is handed to the processor next, and whether that choice may cut into the handler that is already running. Each line has an enable bit and a programmable priority. A smaller priority number is more urgent. A runtime grouping setting divides each priority into two parts. The upper part is the preemption level, which allows nesting. The lower part is the subpriority, which only settles ties among requests waiting together.

A rising edge on a request line latches a pending flag. In every cycle the block looks at the lines that are pending, enabled and unmasked, and finds the most urgent one. It issues a one-cycle take strobe with that line's index when the line is allowed to run. On a take, the winner's preemption level is pushed onto an internal stack of active levels. A handler-complete pulse pops the stack, so the active level falls back to that of the interrupted handler. A nonzero threshold masks every line that is no more urgent than the threshold. A global mask bit holds off every line, and its current value can be read, so that software can save it and restore it later.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset no line is pending or enabled, every priority, the grouping and the threshold are zero, the global mask is clear, `take` is low, `act_valid` is low and `nest_depth` is 0.
- R2: A rising edge on `irq_req[i]` sets line i pending at that clock edge. A line that stays high sets it only once. An eligible winner is taken at the next edge: `take` is high for one cycle with `take_id`=i. The take clears the pending flag.
- R3: A line that is pending but disabled (`cfg_kind`=0, `cfg_wdata[0]`=0) is never taken. It stays pending, and it is taken in the cycle after it is enabled.
- R4: Among eligible lines, the lowest priority value wins. The priority is written with `cfg_kind`=1 and is held in `cfg_wdata[7:4]`.
- R5: When priorities are equal, the lower line index wins.
- R6: When a handler is active, a winner is taken only if its preemption level is strictly lower than `act_level`. An equal or higher level waits.
- R7: The grouping is written with `cfg_kind`=2 from `cfg_wdata[3:0]`. It gives the number of low priority bits that are subpriority, up to a limit of 4. The preemption level is priority >> grouping, so a grouping of 0 makes every bit a preemption bit.
- R8: The threshold is written with `cfg_kind`=3 and taken from `cfg_wdata[7:4]`. When it is nonzero, a line whose priority is equal to or greater than it is not taken. A threshold of 0 masks nothing.
- R9: The global mask is written with `cfg_kind`=4 from `cfg_wdata[0]`. While it is set, no line is taken. `gmask` reads back its current value.
- R10: Each take pushes the winner's preemption level, so `act_level` shows it and `nest_depth` rises by 1. A `done` pulse pops one level, and a waiting line that is now allowed is taken at the next edge.
- R11: While `nest_depth` equals STACK_DEPTH, no take happens.
- R12: In a cycle where `done` is high, no take happens. The deferred winner is taken one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Target of the write: 0 enable, 1 priority, 2 grouping, 3 threshold, 4 global mask |
| cfg_index | input | IDX_W | Line addressed by enable and priority writes |
| cfg_wdata | input | 8 | Write data |
| irq_req | input | NUM_IRQ | Request lines; a rising edge latches a pending flag |
| done | input | 1 | Handler-complete / return pulse |
| take | output | 1 | One-cycle strobe: a line is taken |
| take_id | output | IDX_W | Index of the taken line |
| act_valid | output | 1 | A handler is active |
| act_level | output | PRIO_BITS | Preemption level of the innermost active handler |
| nest_depth | output | DEPTH_W | Number of nested active handlers |
| gmask | output | 1 | Current global mask value |

## Verification
A request edge that arrives before clock edge E sets the pending flag at E. The take strobe, `take_id`, `act_level` and `nest_depth` are all registered and change together at E+1. The bench therefore drives for one cycle, releases, and samples one nanosecond after the following edge. A configuration write is registered at its own edge, so a line that the write unmasks is taken one edge later. A `done` pulse pops the stack at its own edge and blocks the take at that edge. The deferred take is therefore checked one cycle after the pop. Every sample is taken just after a rising edge, and every check falls on the exact cycle given above, never in a window of several cycles.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int CFG_KIND_W = 3;

    typedef enum logic [CFG_KIND_W-1:0] {
        CFG_ENABLE = 3'd0,
        CFG_PRIO   = 3'd1,
        CFG_GROUP  = 3'd2,
        CFG_THRESH = 3'd3,
        CFG_GMASK  = 3'd4
    } cfg_kind_e;
endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
    parameter int NUM_IRQ = 8,
    localparam int IDX_W = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] req,
    input  logic               clr,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_IRQ-1:0] pend
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] pend;
        logic [NUM_IRQ-1:0] req_q;
    } pend_t;

    pend_t st_d, st_q;

    // The clear comes first, so a new edge on the same cycle still sets the flag.
    always_comb begin
        st_d       = st_q;
        st_d.req_q = req;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (clr && (clr_idx == IDX_W'(i))) st_d.pend[i] = 1'b0;
            if (req[i] && !st_q.req_q[i])      st_d.pend[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 4,
    localparam int IDX_W = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]                elig,
    input  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio,
    output logic                              win_valid,
    output logic [IDX_W-1:0]                  win_idx,
    output logic [PRIO_BITS-1:0]              win_prio
);
    // Since the preemption field is the upper part of the priority, ordering by
    // (preemption, subpriority) equals ordering by the full value.
    // The strict compare keeps the lower index on a tie.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!win_valid || (prio[i] < win_prio))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int LEVEL_W     = 4,
    parameter int STACK_DEPTH = 4,
    localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [LEVEL_W-1:0] push_level,
    input  logic               pop,
    output logic               top_valid,
    output logic [LEVEL_W-1:0] top_level,
    output logic [DEPTH_W-1:0] depth,
    output logic               full
);
    typedef struct packed {
        logic [STACK_DEPTH-1:0][LEVEL_W-1:0] lvl;
        logic [DEPTH_W-1:0]                  sp;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop && (st_q.sp != '0)) begin
            st_d.sp = st_q.sp - 1'b1;
        end else if (push && (st_q.sp != DEPTH_W'(STACK_DEPTH))) begin
            for (int i = 0; i < STACK_DEPTH; i++) begin
                if (st_q.sp == DEPTH_W'(i)) st_d.lvl[i] = push_level;
            end
            st_d.sp = st_q.sp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        top_level = '0;
        for (int i = 0; i < STACK_DEPTH; i++) begin
            if (st_q.sp == DEPTH_W'(i + 1)) top_level = st_q.lvl[i];
        end
    end

    assign top_valid = (st_q.sp != '0);
    assign depth     = st_q.sp;
    assign full      = (st_q.sp == DEPTH_W'(STACK_DEPTH));
endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
    import irq_nest_pkg::*;
#(
    parameter int NUM_IRQ     = 8,
    parameter int PRIO_BITS   = 4,
    parameter int STACK_DEPTH = 4,
    localparam int IDX_W   = $clog2(NUM_IRQ),
    localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_KIND_W-1:0] cfg_kind,
    input  logic [IDX_W-1:0]      cfg_index,
    input  logic [7:0]            cfg_wdata,
    input  logic [NUM_IRQ-1:0]    irq_req,
    input  logic                  done,
    output logic                  take,
    output logic [IDX_W-1:0]      take_id,
    output logic                  act_valid,
    output logic [PRIO_BITS-1:0]  act_level,
    output logic [DEPTH_W-1:0]    nest_depth,
    output logic                  gmask
);
    typedef struct packed {
        logic [NUM_IRQ-1:0]                en;
        logic [NUM_IRQ-1:0][PRIO_BITS-1:0] prio;
        logic [3:0]                        grp;
        logic [PRIO_BITS-1:0]              thr;
        logic                              gmask;
        logic                              take;
        logic [IDX_W-1:0]                  take_id;
    } arb_t;

    arb_t st_d, st_q;

    logic [NUM_IRQ-1:0]   pend;
    logic [NUM_IRQ-1:0]   elig;
    logic                 win_valid;
    logic [IDX_W-1:0]     win_idx;
    logic [PRIO_BITS-1:0] win_prio;
    logic [PRIO_BITS-1:0] win_field;
    logic                 stk_full;
    logic                 fire;
    int                   sub_n;

    irq_pend_track #(.NUM_IRQ(NUM_IRQ)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .clr     (fire),
        .clr_idx (win_idx),
        .pend    (pend)
    );

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
        assign elig[g] = pend[g] && st_q.en[g] && !st_q.gmask &&
                         ((st_q.thr == '0) || (st_q.prio[g] < st_q.thr));
    end

    irq_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_pick (
        .elig      (elig),
        .prio      (st_q.prio),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    irq_level_stack #(.LEVEL_W(PRIO_BITS), .STACK_DEPTH(STACK_DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (fire),
        .push_level (win_field),
        .pop        (done),
        .top_valid  (act_valid),
        .top_level  (act_level),
        .depth      (nest_depth),
        .full       (stk_full)
    );

    // The grouping value counts the subpriority bits, up to PRIO_BITS.
    always_comb begin
        sub_n     = (int'(st_q.grp) > PRIO_BITS) ? PRIO_BITS : int'(st_q.grp);
        win_field = win_prio >> sub_n;
        fire      = win_valid && !done && !stk_full &&
                    (!act_valid || (win_field < act_level));
    end

    always_comb begin
        st_d         = st_q;
        st_d.take    = fire;
        st_d.take_id = fire ? win_idx : st_q.take_id;
        if (cfg_we) begin
            case (cfg_kind)
                CFG_ENABLE: st_d.en[cfg_index]   = cfg_wdata[0];
                CFG_PRIO:   st_d.prio[cfg_index] = cfg_wdata[7 -: PRIO_BITS];
                CFG_GROUP:  st_d.grp             = cfg_wdata[3:0];
                CFG_THRESH: st_d.thr             = cfg_wdata[7 -: PRIO_BITS];
                CFG_GMASK:  st_d.gmask           = cfg_wdata[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take    = st_q.take;
    assign take_id = st_q.take_id;
    assign gmask   = st_q.gmask;
endmodule

// File: rtl/irq_nest_arb_chk.sv
module irq_nest_arb_chk #(
    parameter int PRIO_BITS   = 4,
    parameter int STACK_DEPTH = 4,
    localparam int DEPTH_W = $clog2(STACK_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 done,
    input logic                 take,
    input logic                 act_valid,
    input logic [PRIO_BITS-1:0] act_level,
    input logic [DEPTH_W-1:0]   nest_depth,
    input logic                 gmask
);
    assert_gmask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gmask) |-> !take);

    assert_strict_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && $past(act_valid)) |-> (act_level < $past(act_level)));

    assert_done_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> !take);

    assert_take_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (act_valid && (nest_depth == DEPTH_W'($past(nest_depth) + 1'b1))));

    assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        nest_depth <= DEPTH_W'(STACK_DEPTH));
endmodule

bind irq_nest_arb irq_nest_arb_chk #(
    .PRIO_BITS   (PRIO_BITS),
    .STACK_DEPTH (STACK_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .take       (take),
    .act_valid  (act_valid),
    .act_level  (act_level),
    .nest_depth (nest_depth),
    .gmask      (gmask)
);

// File: tb/irq_nest_arb_bench.sv
`timescale 1ns/1ps
module irq_nest_arb_bench;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_kind = '0;
    logic [2:0] cfg_index = '0;
    logic [7:0] cfg_wdata = '0;
    logic [N-1:0] irq_req = '0;
    logic       done = 1'b0;
    logic       take;
    logic [2:0] take_id;
    logic       act_valid;
    logic [3:0] act_level;
    logic [2:0] nest_depth;
    logic       gmask;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    irq_nest_arb u_irq_nest_arb (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_index(cfg_index), .cfg_wdata(cfg_wdata), .irq_req(irq_req),
        .done(done), .take(take), .take_id(take_id), .act_valid(act_valid),
        .act_level(act_level), .nest_depth(nest_depth), .gmask(gmask)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_take(input string req, input bit exp_take, input int exp_id);
        chk(take == exp_take, req, "take", int'(take), int'(exp_take));
        if (exp_take) chk(take_id == 3'(exp_id), req, "take_id", int'(take_id), exp_id);
    endtask

    task automatic expect_nest(input string req, input int dep, input int lvl);
        chk(nest_depth == 3'(dep), req, "nest_depth", int'(nest_depth), dep);
        if (dep != 0) chk(act_level == 4'(lvl), req, "act_level", int'(act_level), lvl);
    endtask

    task automatic wr(input int kind, input int idx, input int data);
        cfg_we = 1'b1; cfg_kind = 3'(kind); cfg_index = 3'(idx); cfg_wdata = 8'(data);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic setup_line(input int idx, input int p);
        wr(1, idx, p << 4);
        wr(0, idx, 1);
    endtask

    task automatic fire(input int line);
        irq_req = N'(1) << line;
        step();
        irq_req = '0;
        step();
    endtask

    task automatic ret();
        done = 1'b1;
        step();
        done = 1'b0;
    endtask

    task automatic t_reset();
        expect_take("R1", 1'b0, 0);
        chk(act_valid == 1'b0, "R1", "act_valid", int'(act_valid), 0);
        expect_nest("R1", 0, 0);
        chk(gmask == 1'b0, "R1", "gmask", int'(gmask), 0);
    endtask

    task automatic t_basic();
        setup_line(3, 2);
        irq_req = N'(1) << 3;
        step();
        step();
        expect_take("R2", 1'b1, 3);
        expect_nest("R10", 1, 2);
        step();
        expect_take("R2 held line no retake", 1'b0, 0);
        irq_req = '0;
        ret();
        expect_nest("R10 pop", 0, 0);
    endtask

    task automatic t_disabled();
        wr(1, 5, 1 << 4);
        fire(5);
        expect_take("R3 disabled", 1'b0, 0);
        step();
        expect_take("R3 disabled", 1'b0, 0);
        wr(0, 5, 1);
        step();
        expect_take("R3 enabled later", 1'b1, 5);
        ret();
    endtask

    task automatic t_order();
        setup_line(1, 6);
        setup_line(2, 3);
        setup_line(4, 3);
        irq_req = (N'(1) << 1) | (N'(1) << 2) | (N'(1) << 4);
        step();
        irq_req = '0;
        step();
        expect_take("R5 tie lower index", 1'b1, 2);
        step();
        expect_take("R6 equal level waits", 1'b0, 0);
        ret();
        expect_take("R12", 1'b0, 0);
        step();
        expect_take("R4 next most urgent", 1'b1, 4);
        expect_nest("R10", 1, 3);
        ret();
        step();
        expect_take("R4 last", 1'b1, 1);
        expect_nest("R10", 1, 6);
        ret();
    endtask

    task automatic t_group();
        setup_line(0, 5);
        setup_line(6, 4);
        fire(0);
        expect_take("R7 group0", 1'b1, 0);
        fire(6);
        expect_take("R6 lower level preempts", 1'b1, 6);
        expect_nest("R7 group0 level", 2, 4);
        ret();
        expect_nest("R10 back to outer", 1, 5);
        ret();
        wr(2, 0, 2);
        fire(0);
        expect_take("R7 group2", 1'b1, 0);
        expect_nest("R7 group2 level", 1, 1);
        fire(6);
        expect_take("R7 subpriority no preempt", 1'b0, 0);
        ret();
        step();
        expect_take("R10 waiting after pop", 1'b1, 6);
        expect_nest("R7", 1, 1);
        ret();
        wr(2, 0, 0);
    endtask

    task automatic t_done_clash();
        setup_line(7, 1);
        fire(0);
        expect_take("R12 setup", 1'b1, 0);
        irq_req = N'(1) << 7;
        step();
        irq_req = '0;
        done = 1'b1;
        step();
        done = 1'b0;
        expect_take("R12 done wins", 1'b0, 0);
        expect_nest("R12", 0, 0);
        step();
        expect_take("R12 deferred", 1'b1, 7);
        expect_nest("R12", 1, 1);
        ret();
    endtask

    task automatic t_thresh();
        wr(3, 0, 3 << 4);
        fire(2);
        expect_take("R8 equal to threshold blocked", 1'b0, 0);
        fire(3);
        expect_take("R8 below threshold", 1'b1, 3);
        ret();
        wr(3, 0, 0);
        step();
        expect_take("R8 zero threshold", 1'b1, 2);
        ret();
    endtask

    task automatic t_gmask();
        wr(4, 0, 1);
        chk(gmask == 1'b1, "R9", "gmask", int'(gmask), 1);
        fire(3);
        expect_take("R9 masked", 1'b0, 0);
        wr(4, 0, 0);
        chk(gmask == 1'b0, "R9", "gmask", int'(gmask), 0);
        step();
        expect_take("R9 unmasked", 1'b1, 3);
        ret();
    endtask

    task automatic t_full();
        for (int i = 0; i < 5; i++) setup_line(i, 8 - i);
        for (int i = 0; i < 4; i++) begin
            fire(i);
            expect_take("R11 fill", 1'b1, i);
            expect_nest("R11 fill", i + 1, 8 - i);
        end
        fire(4);
        expect_take("R11 full blocks", 1'b0, 0);
        expect_nest("R11 full", 4, 5);
        ret();
        step();
        expect_take("R11 after pop", 1'b1, 4);
        expect_nest("R11", 4, 4);
        for (int i = 0; i < 4; i++) ret();
        expect_nest("R10 empty", 0, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_disabled();
        t_order();
        t_group();
        t_done_clash();
        t_thresh();
        t_gmask();
        t_full();
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        summary();
    end
endmodule